// File: doc/BRIEF.md
# Serial Command Decoder for a Four-Channel Wiper Controller

This block is the serial slave front end of a four-channel digital potentiometer controller. A host shifts 16-bit command words into the block while chip select is low. Nothing acts on those bits until chip select goes high again. At that point the block checks how many bits arrived. It then splits the last 16 into an operation code, a channel address and a data byte, and applies the result to four 6-bit wiper registers and their four non-volatile shadow copies. The shadow copies are modelled as a plain register array.

The serial pins are oversampled in the system clock domain through two-flop synchronizers, so the serial clock must run well below the system clock. In practice each serial clock phase must last at least six system clocks. The block accepts SPI mode 0 (clock idles low) and mode 3 (clock idles high). In both modes, data is captured on the rising serial clock edge.

The serial output lets several parts be daisy-chained. It drives the word that was held before the frame, most significant bit first, and it changes on the falling serial clock edge. It is enabled only while chip select is low.

Two active-low control inputs act beside the serial path. Write protect freezes the wipers and the shadow copies but still allows restores. Preset reloads every wiper from its shadow copy.

Top module: `potctl_spi_top`

## Requirements
- R1: Received bits enter most significant bit first on rising serial clock edges. No wiper changes while chip select stays low, even after a full 16 bits.
- R2: At chip select rising, a nonzero bit count that is a multiple of 16 (for example 32) executes the last 16 bits received. The word layout is operation in bits 15:12, channel address in bits 11:8 and data in bits 7:0.
- R3: A frame whose bit count is not a multiple of 16 (for example 8, 15 or 17) executes nothing, and the bit counter starts again from zero.
- R4: A chip select pulse with no serial clock edges re-executes the last executed word. Before any word has been executed since reset, such a pulse does nothing.
- R5: Operation 0xB writes data bits 5:0 into the wiper selected by address 0 to 3. An address of 4 or more has no effect. Operation codes other than 0x1, 0x2, 0x4, 0x5, 0x8 and 0xB have no effect.
- R6: Operation 0x4 increments the addressed wiper and stops at 63. Operation 0x5 decrements it and stops at 0.
- R7: Reset loads 32 into every wiper and every shadow copy. Operation 0x2 copies the addressed wiper into its shadow copy.
- R8: Operation 0x1 reloads the addressed wiper from its shadow copy. Operation 0x8 reloads all four wipers from their shadow copies.
- R9: While write protect (active low) is asserted, operations 0xB, 0x4, 0x5 and 0x2 change nothing. Operations 0x1 and 0x8 still restore.
- R10: While preset (active low) is asserted, every wiper is loaded from its shadow copy. This also works under write protect, and preset takes priority over a serial command in the same cycle.
- R11: During a frame, the serial output presents the 16 bits held before the frame, most significant bit first, and moves to the next bit on each falling serial clock edge. The output enable is low while chip select is high.
- R12: Mode 3 framing (serial clock idle high) gives the same decoding and output behaviour as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 or mode 3 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out, for daisy chaining |
| spi_miso_oe | output | 1 | Output enable for spi_miso; high only while selected |
| wp_n | input | 1 | Active-low write protect |
| pr_n | input | 1 | Active-low preset, reloads wipers from shadow copies |
| wiper | output | 24 | Four 6-bit wiper values, channel 0 in bits 5:0 |

## Verification
A wrong bit counter shows up at chip select rising as a frame that executes when it should not, or that stays silent when it should run. That error appears on the wiper port within a few system clocks of the edge.

A corrupted shift register or last-command register does not show on the wipers until a word executes or a replay pulse arrives. Before that, it shows on the serial output during the very next frame, bit by bit, at each falling clock edge.

A wrong shadow copy stays hidden until a restore command or a preset pulse. The stimulus therefore pairs every save with a later restore, and every write-protected save with a restore that exposes whether the save was blocked.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  // Operation codes carried in word bits 15:12
  typedef enum logic [3:0] {
    OP_NOP         = 4'h0,
    OP_RESTORE_ONE = 4'h1,
    OP_SAVE_ONE    = 4'h2,
    OP_INC         = 4'h4,
    OP_DEC         = 4'h5,
    OP_RESTORE_ALL = 4'h8,
    OP_WRITE       = 4'hB
  } op_e;

  localparam int OP_LSB   = 12;
  localparam int ADDR_LSB = 8;
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/potctl_frame_rx.sv
module potctl_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  output logic               frame_evt,
  output logic               replay_evt,
  output logic [FRAME_W-1:0] word,
  output logic               miso,
  output logic               miso_oe
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_d, cs_d;
  logic               rise, fall, cs_start, cs_end, active;
  logic [CNT_W-1:0]   bit_cnt;
  logic               seen;
  logic [FRAME_W-1:0] shreg;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign cs_start = cs_d & ~cs_n_s;
  assign cs_end   = ~cs_d & cs_n_s;
  assign active   = ~cs_n_s;
  assign word     = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cs_d       <= 1'b1;
      bit_cnt    <= '0;
      seen       <= 1'b0;
      shreg      <= '0;
      miso       <= 1'b0;
      miso_oe    <= 1'b0;
      frame_evt  <= 1'b0;
      replay_evt <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      cs_d       <= cs_n_s;
      miso_oe    <= active;
      frame_evt  <= 1'b0;
      replay_evt <= 1'b0;
      if (cs_start) begin
        bit_cnt <= '0;
        seen    <= 1'b0;
        miso    <= shreg[FRAME_W-1];
      end else if (active) begin
        if (rise) begin
          shreg   <= {shreg[FRAME_W-2:0], mosi_s};
          bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
          seen    <= 1'b1;
        end
        if (fall) miso <= shreg[FRAME_W-1];
      end
      if (cs_end) begin
        // zero clocks: replay; whole frames: execute; anything else: drop
        if (!seen)              replay_evt <= 1'b1;
        else if (bit_cnt == '0) frame_evt  <= 1'b1;
        bit_cnt <= '0;
        seen    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/potctl_wiper_exec.sv
module potctl_wiper_exec
  import potctl_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int CHANNELS = 4,
  parameter int WIPER_W  = 6,
  parameter int NVM_INIT = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_evt,
  input  logic                         replay_evt,
  input  logic [FRAME_W-1:0]           word,
  input  logic                         wp_act,
  input  logic                         preset_act,
  output logic [CHANNELS*WIPER_W-1:0]  wiper_flat,
  output logic [CHANNELS*WIPER_W-1:0]  nvm_flat,
  output logic                         restore_go
);
  localparam int SEL_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam logic [WIPER_W-1:0] W_MAX  = '1;
  localparam logic [WIPER_W-1:0] W_INIT = WIPER_W'(NVM_INIT);

  logic [FRAME_W-1:0] last_word;
  logic               last_valid;
  logic               go;
  logic [FRAME_W-1:0] cmd;
  op_e                op;
  logic [3:0]         addr;
  logic [WIPER_W-1:0] data;
  logic               addr_ok;

  assign go      = frame_evt | (replay_evt & last_valid);
  assign cmd     = frame_evt ? word : last_word;
  assign op      = op_e'(cmd[OP_LSB +: 4]);
  assign addr    = cmd[ADDR_LSB +: 4];
  assign data    = cmd[WIPER_W-1:0];
  assign addr_ok = 32'(addr) < CHANNELS;
  assign restore_go = go && (op == OP_RESTORE_ONE || op == OP_RESTORE_ALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_word  <= '0;
      last_valid <= 1'b0;
    end else if (frame_evt) begin
      last_word  <= word;
      last_valid <= 1'b1;
    end
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [WIPER_W-1:0] wip, nvm;
    logic               hit;

    assign hit = addr_ok && (addr[SEL_W-1:0] == SEL_W'(i));
    assign wiper_flat[i*WIPER_W +: WIPER_W] = wip;
    assign nvm_flat[i*WIPER_W +: WIPER_W]   = nvm;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wip <= W_INIT;
        nvm <= W_INIT;
      end else if (preset_act) begin
        wip <= nvm;
      end else if (go) begin
        unique case (op)
          OP_RESTORE_ONE: if (hit) wip <= nvm;
          OP_RESTORE_ALL: wip <= nvm;
          OP_SAVE_ONE:    if (hit && !wp_act) nvm <= wip;
          OP_INC:         if (hit && !wp_act && wip != W_MAX) wip <= wip + 1'b1;
          OP_DEC:         if (hit && !wp_act && wip != '0) wip <= wip - 1'b1;
          OP_WRITE:       if (hit && !wp_act) wip <= data;
          default:        ;
        endcase
      end
    end
  end
endmodule

// File: rtl/potctl_spi_top.sv
module potctl_spi_top #(
  parameter int FRAME_W  = 16,
  parameter int CHANNELS = 4,
  parameter int WIPER_W  = 6,
  parameter int NVM_INIT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_oe,
  input  logic                        wp_n,
  input  logic                        pr_n,
  output logic [CHANNELS*WIPER_W-1:0] wiper
);
  logic [4:0]               pins_s;
  logic                     sclk_s, cs_n_s, mosi_s, wp_act, preset_act;
  logic                     frame_evt, replay_evt, restore_go;
  logic [FRAME_W-1:0]       word;
  logic [CHANNELS*WIPER_W-1:0] nvm_flat;

  potctl_sync #(.W(5), .RST(5'b01011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_cs_n, spi_mosi, wp_n, pr_n}),
    .q     (pins_s)
  );

  assign sclk_s     = pins_s[4];
  assign cs_n_s     = pins_s[3];
  assign mosi_s     = pins_s[2];
  assign wp_act     = ~pins_s[1];
  assign preset_act = ~pins_s[0];

  potctl_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sclk_s),
    .cs_n_s     (cs_n_s),
    .mosi_s     (mosi_s),
    .frame_evt  (frame_evt),
    .replay_evt (replay_evt),
    .word       (word),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe)
  );

  potctl_wiper_exec #(
    .FRAME_W  (FRAME_W),
    .CHANNELS (CHANNELS),
    .WIPER_W  (WIPER_W),
    .NVM_INIT (NVM_INIT)
  ) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_evt  (frame_evt),
    .replay_evt (replay_evt),
    .word       (word),
    .wp_act     (wp_act),
    .preset_act (preset_act),
    .wiper_flat (wiper),
    .nvm_flat   (nvm_flat),
    .restore_go (restore_go)
  );
endmodule

// File: rtl/potctl_spi_chk.sv
module potctl_spi_chk #(
  parameter int CHANNELS = 4,
  parameter int WIPER_W  = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        spi_cs_n,
  input logic                        spi_miso_oe,
  input logic [CHANNELS*WIPER_W-1:0] wiper,
  input logic [CHANNELS*WIPER_W-1:0] nvm_flat,
  input logic                        wp_act,
  input logic                        preset_act,
  input logic                        frame_evt,
  input logic                        replay_evt,
  input logic                        restore_go
);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

  // R1
  decode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_evt && !replay_evt && !preset_act) |=> $stable(wiper));

  // R9
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_act && !preset_act && !restore_go) |=> $stable(wiper));

  // R9
  wp_nvm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_act |=> $stable(nvm_flat));

  // R10
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_act |=> (wiper == $past(nvm_flat)));

  // R4
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_evt && replay_evt));
endmodule

bind potctl_spi_top potctl_spi_chk #(.CHANNELS(CHANNELS), .WIPER_W(WIPER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso_oe (spi_miso_oe),
  .wiper       (wiper),
  .nvm_flat    (nvm_flat),
  .wp_act      (wp_act),
  .preset_act  (preset_act),
  .frame_evt   (frame_evt),
  .replay_evt  (replay_evt),
  .restore_go  (restore_go)
);

// File: tb/potctl_spi_top_bench.sv
module potctl_spi_top_bench;
  localparam int CH = 4;
  localparam int W  = 6;
  localparam int H  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic wp_n = 1'b1, pr_n = 1'b1;
  logic spi_miso, spi_miso_oe;
  logic [CH*W-1:0] wiper;

  potctl_spi_top u_potctl_spi_top (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wp_n(wp_n), .pr_n(pr_n), .wiper(wiper)
  );

  typedef struct {
    string           req;
    logic [CH*W-1:0] val;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [W-1:0] m_wip[CH];
  logic [W-1:0] m_nvm[CH];
  logic [15:0]  m_last = '0, m_sh = '0;
  bit           m_valid = 0, m_wp = 0, mode3 = 0;

  function automatic logic [CH*W-1:0] pack();
    logic [CH*W-1:0] v;
    for (int i = 0; i < CH; i++) v[i*W +: W] = m_wip[i];
    return v;
  endfunction

  function automatic void apply(logic [15:0] w);
    logic [3:0] op, a;
    logic [W-1:0] d;
    bit hit;
    op = w[15:12]; a = w[11:8]; d = w[W-1:0]; hit = (a < 4'(CH));
    case (op)
      4'h1: if (hit) m_wip[a[1:0]] = m_nvm[a[1:0]];
      4'h8: for (int i = 0; i < CH; i++) m_wip[i] = m_nvm[i];
      4'h2: if (hit && !m_wp) m_nvm[a[1:0]] = m_wip[a[1:0]];
      4'h4: if (hit && !m_wp && m_wip[a[1:0]] != 6'd63) m_wip[a[1:0]] = m_wip[a[1:0]] + 1'b1;
      4'h5: if (hit && !m_wp && m_wip[a[1:0]] != 6'd0) m_wip[a[1:0]] = m_wip[a[1:0]] - 1'b1;
      4'hB: if (hit && !m_wp) m_wip[a[1:0]] = d;
      default: ;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wip(string req);
    exp_t e;
    e.req = req;
    e.val = pack();
    q.push_back(e);
    idle(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (wiper !== e.val) begin
        n_bad++;
        $display("FAIL %s wiper actual=%h expected=%h", e.req, wiper, e.val);
      end
    end
  end

  task automatic shift(logic [31:0] bits, int n);
    @(negedge clk);
    spi_sclk = mode3;
    spi_cs_n = 1'b0;
    idle(H);
    if (n > 0) check("R11 oe", 32'(spi_miso_oe), 32'd1);
    for (int k = n - 1; k >= 0; k--) begin
      if (mode3) spi_sclk = 1'b0;
      spi_mosi = bits[k];
      idle(H);
      check(mode3 ? "R12 miso" : "R11 miso", 32'(spi_miso), 32'(m_sh[15]));
      spi_sclk = 1'b1;
      m_sh = {m_sh[14:0], bits[k]};
      idle(H);
      if (!mode3) spi_sclk = 1'b0;
    end
  endtask

  task automatic release_cs(int n, string req);
    spi_cs_n = 1'b1;
    idle(12);
    if (n == 0) begin
      if (m_valid) apply(m_last);
    end else if (n % 16 == 0) begin
      m_last  = m_sh;
      m_valid = 1;
      apply(m_sh);
    end
    expect_wip(req);
    check("R11 oe idle", 32'(spi_miso_oe), 32'd0);
  endtask

  task automatic frame(logic [31:0] bits, int n, string req);
    shift(bits, n);
    release_cs(n, req);
  endtask

  task automatic cmd(logic [3:0] op, logic [3:0] a, logic [7:0] d, string req);
    frame({16'h0, op, a, d}, 16, req);
  endtask

  task automatic preset_pulse(string req);
    @(negedge clk);
    pr_n = 1'b0;
    idle(6);
    pr_n = 1'b1;
    idle(6);
    for (int i = 0; i < CH; i++) m_wip[i] = m_nvm[i];
    expect_wip(req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < CH; i++) begin m_wip[i] = 6'd32; m_nvm[i] = 6'd32; end
    idle(5);
    rst_n = 1'b1;
    idle(4);
    expect_wip("R7 reset");
    check("R11 oe reset", 32'(spi_miso_oe), 32'd0);

    frame(32'h0, 0, "R4 first pulse");
    cmd(4'hB, 4'h0, 8'h15, "R5 write ch0");
    cmd(4'hB, 4'h2, 8'hFF, "R5 six bits");
    cmd(4'hB, 4'h5, 8'h01, "R5 bad address");
    cmd(4'h7, 4'h1, 8'h01, "R5 undefined op");
    frame({4'hB, 4'h1, 8'h01, 4'hB, 4'h1, 8'h2A}, 32, "R2 32-bit frame");
    frame(32'h0000_B30C, 15, "R3 15 bits");
    frame(32'h0001_B30C, 17, "R3 17 bits");
    frame(32'h0000_00B3, 8, "R3 8 bits");

    shift(32'h0000_B307, 16);
    idle(12);
    expect_wip("R1 held frame");
    release_cs(16, "R1 after release");

    cmd(4'h4, 4'h0, 8'h00, "R6 inc");
    frame(32'h0, 0, "R4 replay inc");
    frame(32'h0, 0, "R4 replay again");
    cmd(4'hB, 4'h1, 8'h3F, "R5 write 63");
    cmd(4'h4, 4'h1, 8'h00, "R6 inc saturates");
    cmd(4'hB, 4'h3, 8'h00, "R5 write 0");
    cmd(4'h5, 4'h3, 8'h00, "R6 dec saturates");
    cmd(4'h5, 4'h1, 8'h00, "R6 dec");

    cmd(4'h2, 4'h0, 8'h00, "R7 save ch0");
    cmd(4'hB, 4'h0, 8'h00, "R5 clear ch0");
    cmd(4'h1, 4'h0, 8'h00, "R8 restore ch0");
    cmd(4'h8, 4'h0, 8'h00, "R8 restore all");

    wp_n = 1'b0; m_wp = 1; idle(4);
    cmd(4'hB, 4'h2, 8'h09, "R9 write blocked");
    cmd(4'h4, 4'h0, 8'h00, "R9 inc blocked");
    cmd(4'h5, 4'h1, 8'h00, "R9 dec blocked");
    wp_n = 1'b1; m_wp = 0; idle(4);
    cmd(4'hB, 4'h1, 8'h05, "R5 write ch1");
    wp_n = 1'b0; m_wp = 1; idle(4);
    cmd(4'h2, 4'h1, 8'h00, "R9 save blocked");
    cmd(4'h8, 4'h0, 8'h00, "R9 restore allowed");

    wp_n = 1'b1; m_wp = 0; idle(4);
    cmd(4'hB, 4'h2, 8'h11, "R5 write ch2");
    cmd(4'hB, 4'h3, 8'h22, "R5 write ch3");
    wp_n = 1'b0; m_wp = 1; idle(4);
    preset_pulse("R10 preset under wp");
    wp_n = 1'b1; m_wp = 0; idle(4);

    @(negedge clk);
    spi_sclk = 1'b1; mode3 = 1; idle(6);
    cmd(4'hB, 4'h1, 8'h11, "R12 mode3 write");
    cmd(4'h4, 4'h1, 8'h00, "R12 mode3 inc");
    frame(32'h0, 0, "R12 mode3 replay");
    frame(32'h0000_0B21, 12, "R12 mode3 12 bits");

    idle(10);
    finish_run();
  end
endmodule